// File: doc/BRIEF.md
# Fractional Accumulator Arithmetic Unit

This block is the accumulator datapath of a single-address machine. Each cycle in which it is enabled, it takes one memory operand word and a 4-bit operation code. It then rewrites the 40-bit accumulator or the 40-bit multiplier-quotient register. Words are sign-plus-fraction numbers: the top bit has weight 2^0 and the lower bits weigh 2^-1 down to 2^-39. All arithmetic is done modulo 2, so every carry out of the sign position is dropped.

A single shared adder does every load and every accumulate. For a load, the accumulator side of the adder is forced to zero. Negation inverts the operand and puts a carry into the least significant stage. The absolute-value variants first pass the operand through a magnitude stage. The unit drives the accumulator, its sign and a strictly-positive flag, which a sequencer uses to decide branches.

Top module: `frac_acc_unit`

## Requirements
- R1: While rst_ni is low, the accumulator and the multiplier-quotient register are both zero, and sign_o and pos_o are both low.
- R2: With en_i low, neither register changes, whatever op_i and opd_i hold.
- R3: Op 0 loads the accumulator with the operand. Op 1 loads it with the two's complement negation of the operand modulo 2^40, so 0 stays 0 and 0x80_0000_0000 (-1) stays itself.
- R4: Op 2 loads the operand's magnitude (negated only when bit 39 is 1). Op 3 loads the negation of that magnitude. 0x80_0000_0000 keeps its own value under both.
- R5: Op 4 adds the operand to the accumulator modulo 2^40. The carry out of bit 39 is discarded.
- R6: Op 5 subtracts the operand from the accumulator: it adds the bitwise complement and a carry of 1 into bit 0, modulo 2^40.
- R7: Op 6 adds the operand's magnitude to the accumulator. Op 7 subtracts that magnitude from it.
- R8: Op 8 loads the multiplier-quotient register from the operand and leaves the accumulator unchanged. Op 9 copies that register into the accumulator.
- R9: Op 10 shifts the accumulator left by one bit. Bit 0 becomes 0 and the old bit 39 is lost.
- R10: Op 11 shifts the accumulator right by one bit, and bit 39 is copied into itself.
- R11: Ops 12 to 15 leave both registers unchanged.
- R12: sign_o equals accumulator bit 39. pos_o is high exactly when bit 39 is 0 and the accumulator is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Apply op_i on this clock edge |
| op_i | input | 4 | Operation code (see R3 to R11) |
| opd_i | input | 40 | Memory operand word |
| acc_o | output | 40 | Accumulator |
| sign_o | output | 1 | Accumulator sign bit |
| pos_o | output | 1 | Accumulator strictly positive |

## Verification
In the same cycle, magnitude conditioning can coincide with the complement-plus-carry of subtraction, and the shift paths with the wrap modulo 2. The bench provokes the first by subtracting the magnitude of a negative operand. It provokes the second by shifting left a value whose bit 38 is set, and by adding two halves so that the sum wraps to -1. Each result is compared with a value the bench computes from R3 to R10 in 40-bit modular arithmetic. The flags are judged against R12 after every operation.

// File: rtl/frac_acc_pkg.sv
package frac_acc_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LD      = 4'd0,
    OP_LD_NEG  = 4'd1,
    OP_LD_MAG  = 4'd2,
    OP_LD_NMAG = 4'd3,
    OP_ADD     = 4'd4,
    OP_SUB     = 4'd5,
    OP_ADD_MAG = 4'd6,
    OP_SUB_MAG = 4'd7,
    OP_LD_MQ   = 4'd8,
    OP_MQ_ACC  = 4'd9,
    OP_SHL     = 4'd10,
    OP_SHR     = 4'd11,
    OP_RSV12   = 4'd12,
    OP_RSV13   = 4'd13,
    OP_RSV14   = 4'd14,
    OP_RSV15   = 4'd15
  } acc_op_e;

  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_SUM,
    SEL_MQ,
    SEL_SHIFT
  } acc_sel_e;

  typedef struct packed {
    acc_sel_e sel;
    logic     use_acc;
    logic     take_mag;
    logic     negate;
    logic     shift_left;
    logic     load_mq;
  } acc_ctl_t;

  function automatic acc_ctl_t decode_op(acc_op_e op);
    acc_ctl_t c;
    c = '{sel: SEL_HOLD, use_acc: 1'b0, take_mag: 1'b0, negate: 1'b0,
          shift_left: 1'b0, load_mq: 1'b0};
    case (op)
      OP_LD:      c.sel = SEL_SUM;
      OP_LD_NEG:  begin c.sel = SEL_SUM; c.negate = 1'b1; end
      OP_LD_MAG:  begin c.sel = SEL_SUM; c.take_mag = 1'b1; end
      OP_LD_NMAG: begin c.sel = SEL_SUM; c.take_mag = 1'b1; c.negate = 1'b1; end
      OP_ADD:     begin c.sel = SEL_SUM; c.use_acc = 1'b1; end
      OP_SUB:     begin c.sel = SEL_SUM; c.use_acc = 1'b1; c.negate = 1'b1; end
      OP_ADD_MAG: begin c.sel = SEL_SUM; c.use_acc = 1'b1; c.take_mag = 1'b1; end
      OP_SUB_MAG: begin
        c.sel = SEL_SUM; c.use_acc = 1'b1; c.take_mag = 1'b1; c.negate = 1'b1;
      end
      OP_LD_MQ:   c.load_mq = 1'b1;
      OP_MQ_ACC:  c.sel = SEL_MQ;
      OP_SHL:     begin c.sel = SEL_SHIFT; c.shift_left = 1'b1; end
      OP_SHR:     c.sel = SEL_SHIFT;
      default:    ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/acc_mag_unit.sv
module acc_mag_unit #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] neg;
  assign neg   = ~val_i + {{(W-1){1'b0}}, 1'b1};
  // -1 maps to itself: complement+1 of 100..0 is 100..0
  assign val_o = (en_i && val_i[W-1]) ? neg : val_i;
endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  assign b_eff = sub_i ? ~b_i : b_i;
  // sub_i is the carry into bit 0; carry out of the sign is dropped
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];

  logic unused_carry;
  assign unused_carry = full[W];
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] val_i,
  input  logic         left_i,
  output logic [W-1:0] val_o
);
  assign val_o = left_i ? {val_i[W-2:0], 1'b0} : {val_i[W-1], val_i[W-1:1]};
endmodule

// File: rtl/frac_acc_unit.sv
module frac_acc_unit
  import frac_acc_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    opd_i,
  output logic [W-1:0]    acc_o,
  output logic            sign_o,
  output logic            pos_o
);
  acc_ctl_t     ctl;
  logic [W-1:0] acc_q, mq_q;
  logic [W-1:0] opd_mag, add_a, sum, shifted, acc_d;

  assign ctl = decode_op(acc_op_e'(op_i));

  acc_mag_unit #(.W(W)) u_mag (
    .val_i(opd_i), .en_i(ctl.take_mag), .val_o(opd_mag)
  );

  assign add_a = ctl.use_acc ? acc_q : '0;

  acc_add_unit #(.W(W)) u_add (
    .a_i(add_a), .b_i(opd_mag), .sub_i(ctl.negate), .sum_o(sum)
  );

  acc_shift_unit #(.W(W)) u_shf (
    .val_i(acc_q), .left_i(ctl.shift_left), .val_o(shifted)
  );

  always_comb begin
    case (ctl.sel)
      SEL_SUM:   acc_d = sum;
      SEL_MQ:    acc_d = mq_q;
      SEL_SHIFT: acc_d = shifted;
      default:   acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mq_q  <= '0;
    end else if (en_i) begin
      acc_q <= acc_d;
      if (ctl.load_mq) mq_q <= opd_i;
    end
  end

  assign acc_o  = acc_q;
  assign sign_o = acc_q[W-1];
  assign pos_o  = !acc_q[W-1] && (acc_q != '0);
endmodule

// File: rtl/frac_acc_chk.sv
module frac_acc_chk
  import frac_acc_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    opd_i,
  input logic [W-1:0]    acc_o,
  input logic            sign_o,
  input logic            pos_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0 && !sign_o && !pos_o));

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));

  a_r3_plain_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_LD) |=> acc_o == $past(opd_i));

  a_r3_neg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_LD_NEG) |=> (acc_o + $past(opd_i)) == '0);

  a_r8_mq_load_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_LD_MQ) |=> $stable(acc_o));

  a_r9_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_SHL) |=> acc_o == {$past(acc_o[W-2:0]), 1'b0});

  a_r10_shift_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_SHR) |=> acc_o == {$past(acc_o[W-1]), $past(acc_o[W-1:1])});

  a_r11_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i >= 4'd12) |=> $stable(acc_o));

  a_r12_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && sign_o));

  a_r12_pos_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o |-> acc_o != '0);
endmodule

bind frac_acc_unit frac_acc_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .opd_i(opd_i),
  .acc_o(acc_o), .sign_o(sign_o), .pos_o(pos_o)
);

// File: tb/frac_acc_unit_tb.sv
module frac_acc_unit_tb;
  import frac_acc_pkg::*;
  localparam int unsigned W = 40;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [W-1:0] NEG_ONE = 40'h80_0000_0000;
  localparam logic [W-1:0] HALF    = 40'h40_0000_0000;
  localparam logic [W-1:0] QUARTER = 40'h20_0000_0000;
  localparam logic [W-1:0] LSB     = 40'h00_0000_0001;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [OP_W-1:0] op = '0;
  logic [W-1:0] opd = '0, acc;
  logic sign, pos;
  int tests = 0, fails = 0;
  logic [W-1:0] exp_acc = '0, exp_mq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_acc_unit #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .opd_i(opd),
    .acc_o(acc), .sign_o(sign), .pos_o(pos)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check({req, "/R12 sign"}, {{(W-1){1'b0}}, sign}, {{(W-1){1'b0}}, exp_acc[W-1]});
    check({req, "/R12 pos"}, {{(W-1){1'b0}}, pos},
          {{(W-1){1'b0}}, (!exp_acc[W-1] && exp_acc != '0)});
  endtask

  function automatic logic [W-1:0] mag(logic [W-1:0] v);
    return v[W-1] ? -v : v;
  endfunction

  // expected next state from the requirements
  task automatic model(logic e, acc_op_e o, logic [W-1:0] m);
    if (!e) return;
    case (o)
      OP_LD:      exp_acc = m;
      OP_LD_NEG:  exp_acc = -m;
      OP_LD_MAG:  exp_acc = mag(m);
      OP_LD_NMAG: exp_acc = -mag(m);
      OP_ADD:     exp_acc = exp_acc + m;
      OP_SUB:     exp_acc = exp_acc - m;
      OP_ADD_MAG: exp_acc = exp_acc + mag(m);
      OP_SUB_MAG: exp_acc = exp_acc - mag(m);
      OP_LD_MQ:   exp_mq  = m;
      OP_MQ_ACC:  exp_acc = exp_mq;
      OP_SHL:     exp_acc = {exp_acc[W-2:0], 1'b0};
      OP_SHR:     exp_acc = {exp_acc[W-1], exp_acc[W-1:1]};
      default:    ;
    endcase
  endtask

  task automatic step(string req, logic e, acc_op_e o, logic [W-1:0] m);
    @(negedge clk);
    en = e; op = o; opd = m;
    model(e, o, m);
    @(negedge clk);
    en = 1'b0;
    check(req, acc, exp_acc);
    check_flags(req);
  endtask

  task automatic t_reset;
    check("R1 acc", acc, '0);
    check("R1 sign", {{(W-1){1'b0}}, sign}, '0);
    check("R1 pos", {{(W-1){1'b0}}, pos}, '0);
    step("R1 mq zero via copy", 1'b1, OP_MQ_ACC, '0);
    check("R1 mq zero", acc, '0);
  endtask

  task automatic t_loads;
    step("R3 load half", 1'b1, OP_LD, HALF);
    check("R3 literal", acc, HALF);
    step("R3 neg half", 1'b1, OP_LD_NEG, HALF);
    check("R3 neg literal", acc, 40'hC0_0000_0000);
    step("R3 neg zero", 1'b1, OP_LD_NEG, '0);
    step("R3 neg of -1", 1'b1, OP_LD_NEG, NEG_ONE);
    check("R3 -1 wrap", acc, NEG_ONE);
    step("R4 mag neg", 1'b1, OP_LD_MAG, 40'hC0_0000_0000);
    check("R4 mag literal", acc, HALF);
    step("R4 mag pos", 1'b1, OP_LD_MAG, QUARTER);
    step("R4 nmag pos", 1'b1, OP_LD_NMAG, HALF);
    step("R4 nmag neg", 1'b1, OP_LD_NMAG, 40'hE0_0000_0000);
    check("R4 nmag literal", acc, 40'hE0_0000_0000);
    step("R4 mag of -1", 1'b1, OP_LD_MAG, NEG_ONE);
    check("R4 -1 mag", acc, NEG_ONE);
    step("R4 nmag of -1", 1'b1, OP_LD_NMAG, NEG_ONE);
  endtask

  task automatic t_accumulate;
    step("R5 seed", 1'b1, OP_LD, HALF);
    step("R5 half+half wraps", 1'b1, OP_ADD, HALF);
    check("R5 wrap literal", acc, NEG_ONE);
    step("R5 -1 + -1 carry dropped", 1'b1, OP_ADD, NEG_ONE);
    check("R5 carry dropped", acc, '0);
    step("R5 add lsb", 1'b1, OP_ADD, LSB);
    step("R6 seed", 1'b1, OP_LD, QUARTER);
    step("R6 quarter-half", 1'b1, OP_SUB, HALF);
    check("R6 literal", acc, 40'hE0_0000_0000);
    step("R6 self cancel", 1'b1, OP_SUB, 40'hE0_0000_0000);
    check("R6 zero", acc, '0);
    step("R6 zero-zero", 1'b1, OP_SUB, '0);
    step("R7 seed", 1'b1, OP_LD, QUARTER);
    step("R7 add mag neg", 1'b1, OP_ADD_MAG, 40'hC0_0000_0000);
    check("R7 literal", acc, 40'h60_0000_0000);
    step("R7 sub mag neg", 1'b1, OP_SUB_MAG, 40'hC0_0000_0000);
    check("R7 sub literal", acc, QUARTER);
    step("R7 sub mag pos", 1'b1, OP_SUB_MAG, HALF);
    step("R7 add mag -1", 1'b1, OP_ADD_MAG, NEG_ONE);
  endtask

  task automatic t_mq;
    step("R8 seed acc", 1'b1, OP_LD, 40'h12_3456_789A);
    step("R8 load mq keeps acc", 1'b1, OP_LD_MQ, 40'h0F_EDCB_A987);
    check("R8 acc kept", acc, 40'h12_3456_789A);
    step("R8 copy mq", 1'b1, OP_MQ_ACC, '0);
    check("R8 copy literal", acc, 40'h0F_EDCB_A987);
  endtask

  task automatic t_shifts;
    step("R9 seed", 1'b1, OP_LD, 40'h60_0000_0001);
    step("R9 shl wraps", 1'b1, OP_SHL, '0);
    check("R9 literal", acc, 40'hC0_0000_0002);
    step("R9 shl drops sign", 1'b1, OP_SHL, '0);
    step("R10 seed", 1'b1, OP_LD, 40'hC0_0000_0000);
    step("R10 shr neg", 1'b1, OP_SHR, '0);
    check("R10 literal", acc, 40'hE0_0000_0000);
    step("R10 seed pos", 1'b1, OP_LD, LSB);
    step("R10 shr lsb out", 1'b1, OP_SHR, '0);
    check("R10 zero", acc, '0);
    step("R10 shr -1", 1'b1, OP_LD, NEG_ONE);
    step("R10 shr -1 result", 1'b1, OP_SHR, '0);
    check("R10 -1 literal", acc, 40'hC0_0000_0000);
  endtask

  task automatic t_idle_and_reserved;
    step("R2 seed", 1'b1, OP_LD, QUARTER);
    step("R2 load mq seed", 1'b1, OP_LD_MQ, HALF);
    step("R2 idle load", 1'b0, OP_LD, 40'h7F_FFFF_FFFF);
    check("R2 acc held", acc, QUARTER);
    step("R2 idle mq load", 1'b0, OP_LD_MQ, 40'h11_1111_1111);
    step("R2 mq held via copy", 1'b1, OP_MQ_ACC, '0);
    check("R2 mq held", acc, HALF);
    for (int k = 12; k < 16; k++) begin
      step("R11 reserved acc", 1'b1, acc_op_e'(k), 40'hAA_AAAA_AAAA);
      check("R11 acc held", acc, HALF);
    end
    step("R11 mq unchanged", 1'b1, OP_LD, '0);
    step("R11 mq copy", 1'b1, OP_MQ_ACC, '0);
    check("R11 mq held", acc, HALF);
    step("R12 zero not pos", 1'b1, OP_LD, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2.5);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_loads();
    t_accumulate();
    t_mq();
    t_shifts();
    t_idle_and_reserved();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule